// File: doc/BRIEF.md
# RMII Transmit Bridge with Generated MAC Clock

This block sits between a MAC that speaks the four-bit media independent interface on its transmit side and a PHY that expects the reduced two-bit interface. Both the bridge and the PHY run from one shared 50 MHz reference clock. The bridge divides that clock to make the transmit clock the MAC launches its nibbles on. It then sends each nibble to the PHY as two dibits.

At 100 Mb/s the generated clock runs at half the reference rate, and each dibit lasts one reference cycle. At 10 Mb/s the generated clock runs at one twentieth of the reference rate, and each dibit is held for ten reference cycles, so the PHY sees the cadence it expects. The MAC's error input is accepted but has no effect. A nibble is sampled at the reference edge on which the generated clock rises. The bridge sends it during the MAC clock period that follows, and the PHY-side enable covers exactly the dibits of nibbles that were sampled with the MAC enable high.

Top module: `mii_rmii_tx_bridge`

## Requirements
- R1: With `fast_mode` = 1, `mac_clk_out` has a period of 2 reference cycles, high for 1 and low for 1.
- R2: With `fast_mode` = 0, `mac_clk_out` has a period of 20 reference cycles, high for 10 and low for 10.
- R3: The nibble and enable held on `mac_nib`/`mac_en` during one `mac_clk_out` period are sampled at the reference edge where `mac_clk_out` next rises, and appear on the PHY side starting right after that edge.
- R4: Each sampled nibble leaves as bits [1:0] first, then bits [3:2]. A byte given low nibble first therefore leaves as [1:0], [3:2], [5:4], [7:6].
- R5: With `fast_mode` = 1, each dibit is held on `phy_dibit` for exactly one reference cycle.
- R6: With `fast_mode` = 0, each dibit is held on `phy_dibit` for exactly ten reference cycles. The output changes only where `mac_clk_out` rises or falls.
- R7: `phy_en` is high for exactly the 2, or 20, reference cycles that carry the dibits of each nibble sampled with `mac_en` = 1. It rises and falls only on the edge where `mac_clk_out` rises.
- R8: While `phy_en` is 0, `phy_dibit` is 2'b00.
- R9: `mac_err` has no effect on any output.
- R10: While `rst_n` is low, `phy_en` = 0, `phy_dibit` = 2'b00 and `mac_clk_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Shared 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| mac_clk_out | output | 1 | Generated MAC transmit clock |
| mac_en | input | 1 | MAC transmit enable |
| mac_err | input | 1 | MAC transmit error (ignored) |
| mac_nib | input | 4 | MAC transmit nibble |
| phy_en | output | 1 | PHY-side transmit enable |
| phy_dibit | output | 2 | PHY-side transmit dibit |

## Verification
The assertions check four things on every cycle. At full rate the MAC clock toggles on every reference cycle. At low rate the PHY outputs are stable everywhere except the two MAC clock edges. The enable changes only where the MAC clock rises. The data is zero whenever the enable is low. Only the bench scenarios can show that a given nibble comes out one MAC period later, with the right dibit order and hold length, and that the error input leaves the output unchanged. For this the bench compares the outputs against a queue of expected dibits on every reference cycle.

// File: rtl/mii_rmii_tx_bridge.sv
module mii_rmii_tx_bridge #(
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 10,
  localparam int CW = $clog2(2 * SLOW_HALF)
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  output logic       mac_clk_out,
  input  logic       mac_en,
  input  logic       mac_err,
  input  logic [3:0] mac_nib,
  output logic       phy_en,
  output logic [1:0] phy_dibit
);

  logic [CW-1:0] phase;
  logic [CW-1:0] half;
  logic [CW-1:0] last;
  logic          wrap;
  logic [3:0]    held_nib;
  logic          held_en;
  logic          unused_err;

  assign unused_err = mac_err;

  assign half = fast_mode ? CW'(FAST_HALF) : CW'(SLOW_HALF);
  assign last = fast_mode ? CW'(2 * FAST_HALF - 1) : CW'(2 * SLOW_HALF - 1);
  assign wrap = (phase >= last);

  always_ff @(posedge ref_clk) begin
    if (!rst_n) begin
      phase    <= '0;
      held_nib <= '0;
      held_en  <= 1'b0;
    end else begin
      phase <= wrap ? '0 : phase + 1'b1;
      if (wrap) begin
        held_nib <= mac_nib;
        held_en  <= mac_en;
      end
    end
  end

  assign mac_clk_out = (phase < half);
  assign phy_en      = held_en;
  assign phy_dibit   = !held_en      ? 2'b00 :
                       (phase < half) ? held_nib[1:0] : held_nib[3:2];

endmodule

module mii_rmii_tx_bridge_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       fast_mode,
  input logic       mac_clk_out,
  input logic       phy_en,
  input logic [1:0] phy_dibit
);

  AST_FAST_TOGGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fast_mode && $past(fast_mode) && $past(rst_n)) |-> (mac_clk_out != $past(mac_clk_out))); // R1

  AST_SLOW_STABLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!fast_mode && $stable(fast_mode) && !$rose(mac_clk_out) && !$fell(mac_clk_out))
      |-> ($stable(phy_dibit) && $stable(phy_en))); // R6

  AST_EN_RISE_ALIGN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(phy_en) |-> $rose(mac_clk_out)); // R7

  AST_EN_FALL_ALIGN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(phy_en) |-> $rose(mac_clk_out)); // R7

  AST_IDLE_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !phy_en |-> (phy_dibit == 2'b00)); // R8

endmodule

bind mii_rmii_tx_bridge mii_rmii_tx_bridge_chk u_chk (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .fast_mode  (fast_mode),
  .mac_clk_out(mac_clk_out),
  .phy_en     (phy_en),
  .phy_dibit  (phy_dibit)
);

// File: tb/mii_rmii_tx_bridge_test.sv
module mii_rmii_tx_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast = 1'b1;
  logic       mac_en = 1'b0;
  logic       mac_err = 1'b0;
  logic [3:0] mac_nib = 4'h0;
  logic       mac_clk_out;
  logic       phy_en;
  logic [1:0] phy_dibit;

  always #4 clk = ~clk;

  mii_rmii_tx_bridge uut (
    .ref_clk(clk), .rst_n(rst_n), .fast_mode(fast), .mac_clk_out(mac_clk_out),
    .mac_en(mac_en), .mac_err(mac_err), .mac_nib(mac_nib),
    .phy_en(phy_en), .phy_dibit(phy_dibit)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  int per = 0, hi = 0;
  bit seen_rise = 0, prev_clk = 1;
  string req = "R3 R4 R5";
  logic [5:0] stim[$];
  logic [2:0] expq[$];

  task automatic check(bit ok, string r, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, expv, cycles);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic tick();
    int h;
    logic [2:0] e;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", 0, 1);
      finish_up();
    end
    h = fast ? 1 : 10;
    if (mac_clk_out && !prev_clk) begin
      if (seen_rise) begin
        check(per == 2 * h, fast ? "R1 period" : "R2 period", per, 2 * h);
        check(hi == h, fast ? "R1 high" : "R2 high", hi, h);
      end
      seen_rise = 1; per = 0; hi = 0;
      for (int i = 0; i < h; i++) expq.push_back({mac_en, mac_en ? mac_nib[1:0] : 2'b00});
      for (int i = 0; i < h; i++) expq.push_back({mac_en, mac_en ? mac_nib[3:2] : 2'b00});
      if (stim.size() > 0) {mac_err, mac_en, mac_nib} = stim.pop_front();
      else {mac_err, mac_en, mac_nib} = 6'b0;
    end
    per++;
    if (mac_clk_out) hi++;
    prev_clk = mac_clk_out;
    e = (expq.size() > 0) ? expq.pop_front() : 3'b000;
    check(phy_en == e[2], "R7 enable", phy_en, e[2]);
    check(phy_dibit == e[1:0], e[2] ? req : "R8 idle data", phy_dibit, e[1:0]);
  endtask

  task automatic restart(bit f);
    @(negedge clk);
    rst_n = 1'b0; fast = f;
    {mac_err, mac_en, mac_nib} = 6'b0;
    stim.delete(); expq.delete();
    seen_rise = 0; prev_clk = 1;
    repeat (3) @(negedge clk);
    check(phy_en == 1'b0, "R10 enable", phy_en, 0);
    check(phy_dibit == 2'b00, "R10 data", phy_dibit, 0);
    check(mac_clk_out == 1'b1, "R10 clock", mac_clk_out, 1);
    rst_n = 1'b1;
  endtask

  task automatic add_byte(logic [7:0] b, bit err);
    stim.push_back({err, 1'b1, b[3:0]});
    stim.push_back({err, 1'b1, b[7:4]});
  endtask

  task automatic add_idle(int n, bit err);
    for (int i = 0; i < n; i++) stim.push_back({err, 1'b0, 4'h0});
  endtask

  task automatic run();
    while (stim.size() > 0 || expq.size() > 0) tick();
    repeat (fast ? 8 : 60) tick();
  endtask

  initial begin
    restart(1'b1);
    req = "R3 R4 R5";
    add_idle(2, 0);
    add_byte(8'h55, 0); add_byte(8'hD5, 0); add_byte(8'hA3, 0);
    add_byte(8'h0F, 0); add_byte(8'h96, 0); add_byte(8'hC3, 0);
    add_idle(3, 0);
    run();

    restart(1'b1);
    req = "R9 error ignored";
    add_idle(2, 1);
    add_byte(8'h3C, 1); add_byte(8'hE7, 0); add_byte(8'h81, 1);
    add_idle(3, 1);
    run();

    restart(1'b1);
    req = "R7 framing";
    add_idle(1, 0);
    add_byte(8'h12, 0); add_byte(8'h34, 0);
    add_idle(1, 0);
    add_byte(8'hFE, 0);
    add_idle(2, 0);
    stim.push_back({1'b0, 1'b1, 4'h9});
    add_idle(3, 0);
    run();

    restart(1'b0);
    req = "R4 R6 slow";
    add_idle(1, 0);
    add_byte(8'h5A, 0); add_byte(8'hE1, 1);
    add_idle(3, 0);
    run();

    finish_up();
  end
endmodule